// File: doc/BRIEF.md
# Shadow-Backed Byte Memory Controller

This block models a byte-wide static memory in which every location has a second, nonvolatile copy behind it. The working array serves ordinary reads and writes. On a store, the whole working array is copied into the shadow copy in one step. On a recall, the whole shadow copy is copied back into the working array. While either operation runs, the block is busy and refuses all accesses.

The host drives active-low chip enable, output enable and write enable signals. It also shares an active-low handshake line with the block, and the controller samples all of these on its clock. A store can be requested in two ways: by pulling the handshake line low, or by raising a power-fail input that stands in for an analog supply comparator. In that second case the controller pulls the handshake line low itself for as long as the store lasts.

A store only runs if something was written since the last store or recall; otherwise the request is dropped. After every reset the block runs a recall on its own. An inhibit-mode input, captured during reset, turns off stores triggered by power loss and leaves only the handshake route.

Top module: `nvshadow_ram`

## Requirements
- R1: While reset is held and for exactly RECALL_CYCLES clock edges after its release, busy_o is high. During that time a recall runs, and it leaves the array clean, so a store request made right after it is dropped.
- R2: dq_oe_o is high and dq_o carries the byte at addr_i when ce_n_i=0, oe_n_i=0, we_n_i=1, the handshake line is 1 and busy_o=0. If any of these conditions does not hold, dq_oe_o is low.
- R3: A write cycle is open while ce_n_i=0, we_n_i=0 and the handshake line is 1. The address and data seen in the last open cycle are written when ce_n_i or we_n_i rises, and the written byte reads back from the cycle after that.
- R4: Whenever we_n_i is low, dq_oe_o is low, even if oe_n_i is low.
- R5: While busy_o is high, reads do not drive the bus, and write cycles change neither the array nor the dirty state.
- R6: A store copies every working byte into the shadow copy when its timer expires. A recall copies the whole shadow copy into the working array, and memory contents after a reset equal those at the last completed store. The array is clean once either operation completes.
- R7: If inhibit mode is off and the array is dirty, pwr_fail_i=1 starts a store. hs_pull_o is high for that whole store and only while busy.
- R8: A low handshake line while idle and dirty starts a store, and hs_pull_o stays low during that store.
- R9: A store request of either kind while the array is clean leaves busy_o low and changes nothing.
- R10: inhibit_i is captured during reset. If it was 1, pwr_fail_i never starts a store, whatever value inhibit_i takes later.
- R11: busy_o stays high for exactly STORE_CYCLES clock edges during a store.
- R12: A store request that arrives while busy neither lengthens the running operation nor starts another one after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the power-on recall |
| inhibit_i | input | 1 | Disables power-loss stores; sampled during reset |
| pwr_fail_i | input | 1 | High when the supply is below the switch threshold |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| hs_n_i | input | 1 | Observed level of the shared handshake line, active low |
| hs_pull_o | output | 1 | Pulls the handshake line low during a power-loss store |
| addr_i | input | ADDR_W | Byte address |
| dq_i | input | DATA_W | Write data |
| dq_o | output | DATA_W | Read data |
| dq_oe_o | output | 1 | Output-driver enable for dq_o |
| busy_o | output | 1 | High during a store or recall |

## Verification
The bench goes after the store-suppression rule. It requests stores right after reset, right after a completed store, and with power-fail held high after its store has finished. A design that ignored the dirty state would show busy in those windows. Accesses attempted in the middle of a store are checked through the read port and by requesting a later store: a design that let them through would return the blocked byte or would accept that store. Recall is checked across resets against values saved by each kind of store, which exposes a shadow copy taken at the wrong moment. An inhibit input that changes after reset exposes a design that reads the mode live instead of latching it.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_RECALL = 2'd1,
      OP_STORE  = 2'd2
   } op_e;
endpackage

// File: rtl/nvs_bus_decode.sv
module nvs_bus_decode #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              hs_n,
   input  logic              blocked,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              rd_en,
   output logic              wr_commit,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   logic wr_open;
   logic wr_open_q;

   assign rd_en   = !ce_n && !oe_n && we_n && hs_n && !blocked;
   assign wr_open = !ce_n && !we_n && hs_n && !blocked;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_open_q <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
      end else begin
         wr_open_q <= wr_open;
         if (wr_open) begin
            wr_addr <= addr;
            wr_data <= wdata;
         end
      end
   end

   // trailing edge of the write window commits the captured byte
   assign wr_commit = wr_open_q && !wr_open && !blocked;
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
   import nvs_pkg::*;
#(
   parameter int STORE_CYCLES  = 1250000,
   parameter int RECALL_CYCLES = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic inhibit,
   input  logic pwr_fail,
   input  logic hs_n,
   input  logic wr_commit,
   output logic busy,
   output logic store_busy,
   output logic hs_pull,
   output logic do_store,
   output logic do_recall,
   output logic dirty,
   output logic inh_q
);
   localparam int MAX_C = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
   localparam int CNT_W = $clog2(MAX_C + 1);
   localparam logic [CNT_W-1:0] STORE_LD  = CNT_W'(STORE_CYCLES - 1);
   localparam logic [CNT_W-1:0] RECALL_LD = CNT_W'(RECALL_CYCLES - 1);

   generate
      if (STORE_CYCLES < 1) begin : g_bad_store
         $error("STORE_CYCLES must be at least 1");
      end
      if (RECALL_CYCLES < 1) begin : g_bad_recall
         $error("RECALL_CYCLES must be at least 1");
      end
   endgenerate

   op_e            state_q;
   logic [CNT_W-1:0] cnt_q;
   logic           auto_q;
   logic           auto_req;
   logic           ext_req;
   logic           expire;

   assign auto_req = pwr_fail && !inh_q;
   assign ext_req  = !hs_n;
   assign expire   = (state_q != OP_IDLE) && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= OP_RECALL;
         cnt_q   <= RECALL_LD;
         dirty   <= 1'b0;
         auto_q  <= 1'b0;
         inh_q   <= inhibit;
      end else begin
         case (state_q)
            OP_IDLE: begin
               if (wr_commit) dirty <= 1'b1;
               if (dirty && (auto_req || ext_req)) begin
                  state_q <= OP_STORE;
                  cnt_q   <= STORE_LD;
                  auto_q  <= auto_req;
               end
            end
            default: begin
               if (expire) begin
                  state_q <= OP_IDLE;
                  dirty   <= 1'b0;
                  auto_q  <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         endcase
      end
   end

   assign busy       = (state_q != OP_IDLE);
   assign store_busy = (state_q == OP_STORE);
   assign hs_pull    = store_busy && auto_q;
   assign do_store   = expire && (state_q == OP_STORE);
   assign do_recall  = expire && (state_q == OP_RECALL);
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              do_store,
   input  logic              do_recall
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] work_q   [DEPTH];
   logic [DATA_W-1:0] shadow_q [DEPTH];

   always_ff @(posedge clk) begin
      if (do_recall)  work_q <= shadow_q;
      else if (wr_en) work_q[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (do_store) shadow_q <= work_q;
   end

   assign rd_data = work_q[rd_addr];
endmodule

// File: rtl/nvshadow_ram.sv
module nvshadow_ram #(
   parameter int ADDR_W        = 11,
   parameter int DATA_W        = 8,
   parameter int STORE_CYCLES  = 1250000,
   parameter int RECALL_CYCLES = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              inhibit_i,
   input  logic              pwr_fail_i,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   input  logic              we_n_i,
   input  logic              hs_n_i,
   output logic              hs_pull_o,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe_o,
   output logic              busy_o
);
   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic              wr_commit;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              do_store;
   logic              do_recall;
   logic              store_busy;
   logic              dirty;
   logic              inh_q;

   nvs_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .clk      (clk),
      .rst      (rst),
      .ce_n     (ce_n_i),
      .oe_n     (oe_n_i),
      .we_n     (we_n_i),
      .hs_n     (hs_n_i),
      .blocked  (busy_o),
      .addr     (addr_i),
      .wdata    (dq_i),
      .rd_en    (dq_oe_o),
      .wr_commit(wr_commit),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data)
   );

   nvs_seq #(.STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .inhibit   (inhibit_i),
      .pwr_fail  (pwr_fail_i),
      .hs_n      (hs_n_i),
      .wr_commit (wr_commit),
      .busy      (busy_o),
      .store_busy(store_busy),
      .hs_pull   (hs_pull_o),
      .do_store  (do_store),
      .do_recall (do_recall),
      .dirty     (dirty),
      .inh_q     (inh_q)
   );

   nvs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk      (clk),
      .wr_en    (wr_commit),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (addr_i),
      .rd_data  (dq_o),
      .do_store (do_store),
      .do_recall(do_recall)
   );
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
   parameter int STORE_CYCLES = 1250000
) (
   input logic clk,
   input logic rst,
   input logic we_n,
   input logic dq_oe,
   input logic busy,
   input logic hs_pull,
   input logic store_busy,
   input logic dirty,
   input logic inh_q
);
   logic [31:0] run_q;

   always_ff @(posedge clk) begin
      if (rst)             run_q <= '0;
      else if (store_busy) run_q <= run_q + 1'b1;
      else                 run_q <= '0;
   end

   p_no_contention_r4: assert property (@(posedge clk) disable iff (rst)
      !we_n |-> !dq_oe);

   p_busy_blocks_read_r5: assert property (@(posedge clk) disable iff (rst)
      busy |-> !dq_oe);

   p_pull_in_store_r7: assert property (@(posedge clk) disable iff (rst)
      hs_pull |-> store_busy);

   p_store_needs_dirty_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(store_busy) |-> $past(dirty));

   p_clean_after_op_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> !dirty);

   p_mode_held_r10: assert property (@(posedge clk) disable iff (rst)
      $stable(inh_q));

   p_store_length_r11: assert property (@(posedge clk) disable iff (rst)
      $fell(store_busy) |-> (run_q == 32'(STORE_CYCLES)));
endmodule

bind nvshadow_ram nvs_checker #(.STORE_CYCLES(STORE_CYCLES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .we_n      (we_n_i),
   .dq_oe     (dq_oe_o),
   .busy      (busy_o),
   .hs_pull   (hs_pull_o),
   .store_busy(store_busy),
   .dirty     (dirty),
   .inh_q     (inh_q)
);

// File: tb/nvshadow_ram_bench.sv
`timescale 1ns/1ps
module nvshadow_ram_bench;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int SC = 40;
   localparam int RC = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic inhibit = 1'b0;
   logic pwr_fail = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hs_drv_n = 1'b1;
   logic hs_line;
   logic hs_pull;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic dq_oe, busy;

   int checks = 0;
   int fails = 0;
   int run_len = 0;
   int last_run = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   assign hs_line = hs_drv_n & ~hs_pull;

   nvshadow_ram #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYCLES(SC), .RECALL_CYCLES(RC)) u_nvshadow_ram (
      .clk(clk), .rst(rst), .inhibit_i(inhibit), .pwr_fail_i(pwr_fail),
      .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n), .hs_n_i(hs_line),
      .hs_pull_o(hs_pull), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out),
      .dq_oe_o(dq_oe), .busy_o(busy)
   );

   always @(negedge clk) begin
      if (busy) run_len++;
      else begin
         if (run_len != 0) last_run = run_len;
         run_len = 0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   task automatic do_reset(input logic inh);
      @(negedge clk);
      rst = 1'b1; inhibit = inh;
      repeat (2) @(negedge clk);
      check("R1 busy in reset", busy, 1);
      check("R1 no drive in reset", dq_oe, 0);
      rst = 1'b0;
      begin
         int n = 0;
         do begin @(negedge clk); n++; end while (busy && n < 1000);
         check("R1 recall length", n, RC);
      end
   endtask

   task automatic do_write(input int a, input int d, input bit by_ce);
      addr = AW'(a); dq_in = DW'(d); ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      check("R4 off while we low", dq_oe, 0);
      if (by_ce) ce_n = 1'b1; else we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic do_read(input string req, input int a, input int exp);
      addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
      #1;
      check({req, " oe"}, dq_oe, busy ? 0 : 1);
      if (!busy) check({req, " data"}, dq_out, exp);
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic hs_pulse();
      hs_drv_n = 1'b0;
      @(negedge clk);
      hs_drv_n = 1'b1;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 5000) begin @(negedge clk); n++; end
      repeat (2) @(negedge clk);
   endtask

   task automatic t_clean_after_reset();
      hs_pulse();
      check("R1 clean after recall", busy, 0);
      repeat (2) @(negedge clk);
      check("R1 still idle", busy, 0);
   endtask

   task automatic t_basic_access();
      do_write(0, 8'hA5, 1'b0);
      do_write(2047, 8'h5A, 1'b1);
      do_write(5, 8'h3C, 1'b0);
      do_read("R3 addr0", 0, 8'hA5);
      do_read("R3 addr2047 ce-end", 2047, 8'h5A);
      do_read("R2 addr5", 5, 8'h3C);
      addr = 5; ce_n = 1'b0; oe_n = 1'b1; #1;
      check("R2 oe high gives no drive", dq_oe, 0);
      oe_n = 1'b0; we_n = 1'b0; #1;
      check("R4 write with oe low", dq_oe, 0);
      we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
      do_read("R3 unchanged by aborted", 5, 8'h3C);
   endtask

   task automatic t_ext_store();
      hs_pulse();
      check("R8 store started", busy, 1);
      check("R8 no pull", hs_pull, 0);
      do_read("R5 read blocked", 5, 0);
      do_write(5, 8'hEE, 1'b0);
      hs_pulse();
      wait_idle();
      check("R11 store length", last_run, SC);
      check("R12 no second op", busy, 0);
      do_read("R5 write blocked", 5, 8'h3C);
      hs_pulse();
      check("R9 clean store dropped", busy, 0);
      @(negedge clk);
      check("R5 blocked write left clean", busy, 0);
   endtask

   task automatic t_recall_restores();
      do_write(5, 8'h77, 1'b0);
      do_read("R3 new value", 5, 8'h77);
      do_reset(1'b0);
      do_read("R6 recall addr5", 5, 8'h3C);
      do_read("R6 recall addr0", 0, 8'hA5);
      do_read("R6 recall addr2047", 2047, 8'h5A);
   endtask

   task automatic t_auto_store();
      do_write(9, 8'h9A, 1'b0);
      pwr_fail = 1'b1;
      @(negedge clk);
      check("R7 auto store busy", busy, 1);
      check("R7 pull high", hs_pull, 1);
      repeat (10) @(negedge clk);
      check("R7 pull held", hs_pull, 1);
      wait_idle();
      check("R11 auto length", last_run, SC);
      check("R7 pull released", hs_pull, 0);
      repeat (3) @(negedge clk);
      check("R9 held power-fail no repeat", busy, 0);
      pwr_fail = 1'b0;
      do_reset(1'b0);
      do_read("R6 auto-saved byte", 9, 8'h9A);
   endtask

   task automatic t_inhibit();
      do_reset(1'b1);
      do_write(9, 8'h11, 1'b1);
      inhibit = 1'b0;
      pwr_fail = 1'b1;
      repeat (5) @(negedge clk);
      check("R10 power-fail ignored", busy, 0);
      pwr_fail = 1'b0;
      @(negedge clk);
      hs_pulse();
      check("R8 ext store in inhibit", busy, 1);
      check("R8 no pull in inhibit", hs_pull, 0);
      wait_idle();
      do_reset(1'b0);
      do_read("R6 inhibit-mode save", 9, 8'h11);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      do_reset(1'b0);
      t_clean_after_reset();
      t_basic_access();
      t_ext_store();
      t_recall_restores();
      t_auto_store();
      t_inhibit();
      summary();
   end
endmodule